// File: doc/BRIEF.md
# Temperature Sensor Power-Up Sequencer

This block brings an on-chip temperature sensor up and down through a two-bit control word. A host sends single-cycle enable or disable requests. On an enable the sequencer turns on the sensor bias first. It waits out a first settle interval, then adds the output-enable bit and waits out a second settle interval. After that it raises `ready` so that samples may be taken.

A disable request clears the whole control word in one write, whatever stage the sequence has reached. Both settle intervals are given in microseconds. They are converted to clock cycles from a clock-frequency parameter in kHz, rounding up, so that a stage never finishes early. A registered write strobe marks every cycle in which the control word takes a new value. A request for the mode that is already in effect produces no strobe.

Top module: `sensor_pwrseq`

## Requirements
- R1: While reset is high and in the first cycle after it, `sens_ctrl` is 2'b00, `ctrl_wr` is 0 and `ready` is 0.
- R2: An enable request (`cmd_valid`=1, `cmd_enable`=1) while the control word is 2'b00 makes `sens_ctrl` 2'b01 (bit 0 = sensor bias on, bit 1 = output enable) at the next clock edge, with `ctrl_wr` high for that one cycle.
- R3: `sens_ctrl` changes from 2'b01 to 2'b11 exactly EN_CYCLES clock edges after it became 2'b01, never earlier, and `ctrl_wr` pulses at that change.
- R4: `ready` rises exactly OE_CYCLES clock edges after `sens_ctrl` became 2'b11, and is high only while `sens_ctrl` is 2'b11. Entering the ready stage causes no `ctrl_wr` pulse.
- R5: A disable request (`cmd_valid`=1, `cmd_enable`=0) in any stage other than off makes `sens_ctrl` 2'b00 and `ready` 0 at the next edge, with one `ctrl_wr` pulse, and aborts any running settle count.
- R6: A request for the mode already in effect has no effect. A disable while off gives no `ctrl_wr` pulse. An enable during either settle stage or the ready stage does not restart or lengthen the sequence and gives no extra pulse.
- R7: `sens_ctrl` never takes the value 2'b10.
- R8: `ctrl_wr` is high in exactly those cycles where `sens_ctrl` has just taken a new value.
- R9: Each cycle count equals ceil(delay_us × CLK_KHZ / 1000), with a minimum of 1. With CLK_KHZ=33333, the 30 us stage lasts 1000 cycles and the 50 us stage lasts 1667 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request strobe, one cycle per request |
| cmd_enable | input | 1 | 1 = enable request, 0 = disable request |
| sens_ctrl | output | 2 | Control word: bit 0 sensor bias on, bit 1 output enable |
| ctrl_wr | output | 1 | Pulses when the control word takes a new value |
| ready | output | 1 | Sensor output may be sampled |

## Verification
The sequencer is first run through a plain enable, so that both settle stages can be timed edge by edge against the computed counts. Extra enable requests are then issued midway through a settle stage, which shows whether a repeated request restarts the stage or is ignored. Disable requests are placed in each of the settle stages, in the ready stage and while off, which separates a real abort from a redundant request. A second instance runs at a clock frequency whose cycle count is not a whole number, so a rounded-down count can be told apart from a rounded-up one.

// File: rtl/tsen_seq_pkg.sv
package tsen_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_WAIT_EN = 2'd1,
    ST_WAIT_OE = 2'd2,
    ST_READY   = 2'd3
  } seq_state_t;

  localparam logic [1:0] CTRL_OFF  = 2'b00;
  localparam logic [1:0] CTRL_BIAS = 2'b01;
  localparam logic [1:0] CTRL_ALL  = 2'b11;

  // cycles = ceil(us * kHz / 1000), never below one
  function automatic int unsigned settle_cycles(input int unsigned us,
                                                input int unsigned khz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(us) * longint'(khz);
    cyc  = (prod + 64'd999) / 64'd1000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic logic [1:0] ctrl_of(input seq_state_t s);
    case (s)
      ST_OFF:     return CTRL_OFF;
      ST_WAIT_EN: return CTRL_BIAS;
      default:    return CTRL_ALL;
    endcase
  endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         abort,
  output logic         expired,
  output logic         busy
);
  logic [W-1:0] cnt;
  logic         active;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= load;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expired = active && (cnt == '0);
  assign busy    = active;

  // R5: an abort leaves the timer idle on the next cycle
  a_r5_abort_idles: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);

  // R3: an expiry without a reload ends the count
  a_r3_single_expiry: assert property (@(posedge clk) disable iff (rst)
    (expired && !start && !abort) |=> !busy);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import tsen_seq_pkg::*;
#(
  parameter int          W       = 16,
  parameter logic [W-1:0] LOAD_EN = '0,
  parameter logic [W-1:0] LOAD_OE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic         cmd_enable,
  input  logic         expired,
  input  logic         timer_busy,
  output logic         tmr_start,
  output logic [W-1:0] tmr_load,
  output logic         tmr_abort,
  output logic [1:0]   sens_ctrl,
  output logic         ctrl_wr,
  output logic         ready
);
  seq_state_t state, nxt;
  logic       wr_nxt;
  logic       req_on, req_off;

  assign req_on  = cmd_valid && cmd_enable;
  assign req_off = cmd_valid && !cmd_enable;

  always_comb begin
    nxt       = state;
    tmr_start = 1'b0;
    tmr_load  = LOAD_EN;
    tmr_abort = 1'b0;
    wr_nxt    = 1'b0;
    if (req_off && state != ST_OFF) begin
      nxt       = ST_OFF;
      tmr_abort = 1'b1;
      wr_nxt    = 1'b1;
    end else begin
      case (state)
        ST_OFF: if (req_on) begin
          nxt       = ST_WAIT_EN;
          tmr_start = 1'b1;
          tmr_load  = LOAD_EN;
          wr_nxt    = 1'b1;
        end
        ST_WAIT_EN: if (expired) begin
          nxt       = ST_WAIT_OE;
          tmr_start = 1'b1;
          tmr_load  = LOAD_OE;
          wr_nxt    = 1'b1;
        end
        ST_WAIT_OE: if (expired) nxt = ST_READY;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      sens_ctrl <= CTRL_OFF;
      ctrl_wr   <= 1'b0;
      ready     <= 1'b0;
    end else begin
      state     <= nxt;
      sens_ctrl <= ctrl_of(nxt);
      ctrl_wr   <= wr_nxt;
      ready     <= (nxt == ST_READY);
    end
  end

  a_r7_no_oe_alone: assert property (@(posedge clk) disable iff (rst)
    sens_ctrl != 2'b10);

  a_r4_ready_needs_all: assert property (@(posedge clk) disable iff (rst)
    ready |-> (sens_ctrl == CTRL_ALL && !timer_busy));

  a_r5_disable_clears: assert property (@(posedge clk) disable iff (rst)
    req_off |=> (sens_ctrl == CTRL_OFF && !ready));

  a_r6_redundant_off: assert property (@(posedge clk) disable iff (rst)
    (req_off && sens_ctrl == CTRL_OFF) |=> !ctrl_wr);

  a_r8_change_has_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sens_ctrl != $past(sens_ctrl)) |-> ctrl_wr);

  a_r3_wait_needs_timer: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_EN || state == ST_WAIT_OE) |-> timer_busy);

endmodule

// File: rtl/sensor_pwrseq.sv
module sensor_pwrseq
  import tsen_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 100000,
  parameter int unsigned EN_SETTLE_US = 30,
  parameter int unsigned OE_SETTLE_US = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       cmd_enable,
  output logic [1:0] sens_ctrl,
  output logic       ctrl_wr,
  output logic       ready
);
  localparam int unsigned EN_CYCLES = settle_cycles(EN_SETTLE_US, CLK_KHZ);
  localparam int unsigned OE_CYCLES = settle_cycles(OE_SETTLE_US, CLK_KHZ);
  localparam int unsigned MAX_CYC   = (EN_CYCLES > OE_CYCLES) ? EN_CYCLES : OE_CYCLES;
  localparam int          W         = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [W-1:0] LOAD_EN  = W'(EN_CYCLES - 1);
  localparam logic [W-1:0] LOAD_OE  = W'(OE_CYCLES - 1);

  logic         tmr_start, tmr_abort, tmr_expired, tmr_busy;
  logic [W-1:0] tmr_load;

  settle_timer #(.W(W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_start),
    .load    (tmr_load),
    .abort   (tmr_abort),
    .expired (tmr_expired),
    .busy    (tmr_busy)
  );

  pwrseq_fsm #(.W(W), .LOAD_EN(LOAD_EN), .LOAD_OE(LOAD_OE)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_enable (cmd_enable),
    .expired    (tmr_expired),
    .timer_busy (tmr_busy),
    .tmr_start  (tmr_start),
    .tmr_load   (tmr_load),
    .tmr_abort  (tmr_abort),
    .sens_ctrl  (sens_ctrl),
    .ctrl_wr    (ctrl_wr),
    .ready      (ready)
  );

endmodule

// File: tb/tb_sensor_pwrseq.sv
`timescale 1ns/1ps
module tb_sensor_pwrseq;
  localparam int N_EN  = 3000;  // 30 us at 100 MHz
  localparam int N_OE  = 5000;  // 50 us at 100 MHz
  localparam int N2_EN = 1000;  // ceil(30*33333/1000)
  localparam int N2_OE = 1667;  // ceil(50*33333/1000)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_enable = 1'b0;
  logic c2_valid = 1'b0, c2_enable = 1'b0;
  logic [1:0] sens_ctrl, s2_ctrl;
  logic ctrl_wr, ready, w2, r2;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sensor_pwrseq dut (.clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .cmd_enable(cmd_enable), .sens_ctrl(sens_ctrl), .ctrl_wr(ctrl_wr), .ready(ready));

  sensor_pwrseq #(.CLK_KHZ(33333)) dut2 (.clk(clk), .rst(rst), .cmd_valid(c2_valid),
    .cmd_enable(c2_enable), .sens_ctrl(s2_ctrl), .ctrl_wr(w2), .ready(r2));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model, stepped at each edge
  int m_st = 0, m_cnt = 0, m_ctrl = 0, m_wr = 0, m_rdy = 0;
  always @(posedge clk) begin
    cyc++;
    m_wr = 0;
    if (rst) begin
      m_st = 0; m_cnt = 0;
    end else if (cmd_valid && !cmd_enable) begin
      if (m_st != 0) begin m_st = 0; m_wr = 1; end
    end else if (cmd_valid && cmd_enable && m_st == 0) begin
      m_st = 1; m_cnt = N_EN; m_wr = 1;
    end else if (m_st == 1) begin
      m_cnt--;
      if (m_cnt == 0) begin m_st = 2; m_cnt = N_OE; m_wr = 1; end
    end else if (m_st == 2) begin
      m_cnt--;
      if (m_cnt == 0) m_st = 3;
    end
    m_ctrl = (m_st == 0) ? 0 : (m_st == 1) ? 1 : 3;
    m_rdy  = (m_st == 3) ? 1 : 0;
    #2;
    if (!rst && !done) begin
      check("R3 ctrl vs model", sens_ctrl, m_ctrl);
      check("R8 ctrl_wr vs model", ctrl_wr, m_wr);
      check("R4 ready vs model", ready, m_rdy);
      check("R7 no 2'b10", (sens_ctrl == 2'b10), 0);
    end
  end

  task automatic send(input bit en);
    @(negedge clk); cmd_valid = 1'b1; cmd_enable = en;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2;
    repeat (4) @(negedge clk);
    check("R1 ctrl in reset", sens_ctrl, 0);
    check("R1 ready in reset", ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ctrl after reset", sens_ctrl, 0);
    check("R1 wr after reset", ctrl_wr, 0);

    // plain enable, timed
    send(1); t0 = cyc;
    check("R2 ctrl after enable", sens_ctrl, 1);
    check("R2 wr after enable", ctrl_wr, 1);
    while (sens_ctrl != 2'b11) @(negedge clk);
    t1 = cyc;
    check("R3 bias settle cycles", t1 - t0, N_EN);
    check("R3 wr at oe", ctrl_wr, 1);
    while (!ready) @(negedge clk);
    t2 = cyc;
    check("R4 oe settle cycles", t2 - t1, N_OE);
    check("R4 no wr on ready", ctrl_wr, 0);

    // redundant enable in ready
    send(1);
    check("R6 enable in ready wr", ctrl_wr, 0);
    check("R6 enable in ready ctrl", sens_ctrl, 3);
    // disable from ready
    send(0);
    check("R5 ctrl after disable", sens_ctrl, 0);
    check("R5 ready after disable", ready, 0);
    check("R5 wr after disable", ctrl_wr, 1);
    // disable while off
    send(0);
    check("R6 disable while off wr", ctrl_wr, 0);

    // enable, repeated enable midway through both stages
    send(1); t0 = cyc;
    idle(1000); send(1);
    while (sens_ctrl != 2'b11) @(negedge clk);
    t1 = cyc;
    check("R6 no restart in bias stage", t1 - t0, N_EN);
    idle(2000); send(1);
    while (!ready) @(negedge clk);
    check("R6 no restart in oe stage", cyc - t1, N_OE);
    send(0);

    // disable inside bias stage then full relaunch
    send(1); idle(500); send(0);
    check("R5 abort in bias stage", sens_ctrl, 0);
    send(1); t0 = cyc;
    while (sens_ctrl != 2'b11) @(negedge clk);
    check("R5 fresh count after abort", cyc - t0, N_EN);
    idle(100); send(0);
    check("R5 abort in oe stage", sens_ctrl, 0);
    check("R5 ready low after oe abort", ready, 0);
    idle(10);

    // rounded-up counts on the second instance
    @(negedge clk); c2_valid = 1'b1; c2_enable = 1'b1;
    @(negedge clk); c2_valid = 1'b0; t0 = cyc;
    check("R9 ctrl2 after enable", s2_ctrl, 1);
    while (s2_ctrl != 2'b11) @(negedge clk);
    t1 = cyc;
    check("R9 ceil bias cycles", t1 - t0, N2_EN);
    while (!r2) @(negedge clk);
    check("R9 ceil oe cycles", cyc - t1, N2_OE);

    idle(5);
    finish_run();
  end
endmodule